// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps the time of day and the calendar date as packed BCD bytes. A prescaler counts enabled cycles of a fast clock enable. It produces a one-second advance pulse and a square wave that runs at one cycle per second. Each advance steps a chain of fields: seconds, minutes, hours, day of week, date, month (with a century flag) and a two-digit year. Carries ripple through the chain within the same clock edge. The date chain corrects for month length, and February has 29 days in years divisible by four.

Each hours byte carries its own encoding. With bit 6 set, the byte holds 1–12 and bit 5 marks PM. With bit 6 clear, it holds 00–23. A loader pushes one field per transfer through a valid/ready write port. The port refuses a transfer only in the cycle in which the counter advances. The writer must then hold valid, address and data stable, and the transfer lands on the following edge, after the advance. A seconds write also restarts the sub-second divider. A hold input freezes the divider and the calendar, but writes are still accepted while it is high.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, the fields read seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), day of week 0x01, date 0x01, month 0x01 (century flag 0) and year 0x00.
- R2: One advance occurs per DIV_COUNT cycles in which `tick_en` is high and `osc_disable` is low. `sec_pulse` is high in the cycle before that edge. Seconds and minutes step 00→59 in BCD and wrap to 00, and the wrap carries into the next field.
- R3: In 24-hour mode (hours bit 6 = 0), hours run 0x00→0x23. The step from 0x23 to 0x00 advances the day.
- R4: In 12-hour mode (bit 6 = 1, bit 5 = PM, bits 4:0 hold 1–12 in BCD), 12 is followed by 1 with AM/PM unchanged, and 11 is followed by 12 with AM/PM toggled. The day advances only on the PM→AM crossing, so 11:59:59 PM (0x71) becomes 12 AM (0x52).
- R5: Day of week counts 1–7, steps once per day advance, and wraps from 7 to 1.
- R6: The date wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months, and in February after 29 when the BCD year is divisible by four, otherwise after 28.
- R7: The month wraps from 12 to 01 and advances the year. A year wrap from 99 to 00 toggles the century flag in month bit 7.
- R8: Write address 0–6 selects seconds, minutes, hours, day of week, date, month or year. Address 7 changes nothing. Unused bits are cleared on a write and always read 0: bit 7 of seconds, minutes and hours, bits 7:6 of date, bits 7:3 of day of week, and bits 6:5 of month.
- R9: An accepted seconds write clears the sub-second divider. The next advance then follows after exactly DIV_COUNT enabled cycles, and the square wave reads low until DIV_COUNT/2 enabled cycles have elapsed.
- R10: `sqw_o` is high while `sqw_en` is high and the divider is in the second half of its count (count ≥ DIV_COUNT/2). Otherwise `sqw_o` is low.
- R11: While `osc_disable` is high, neither the divider nor the calendar moves and no pulse is produced. Writes are still accepted.
- R12: `wr_ready` is low exactly in the cycle in which `sec_pulse` is high. A write held across that cycle is accepted on the next edge and overrides the value that the advance produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Fast clock enable counted by the divider |
| osc_disable | input | 1 | Freezes the divider and the calendar |
| sqw_en | input | 1 | Enables the square-wave output |
| wr_valid | input | 1 | Write transfer request |
| wr_ready | output | 1 | Write accepted at this edge when high |
| wr_addr | input | 3 | Field select for the write |
| wr_data | input | 8 | Packed BCD value to load |
| seconds_o | output | 8 | Seconds field |
| minutes_o | output | 8 | Minutes field |
| hours_o | output | 8 | Hours field with mode and AM/PM bits |
| wday_o | output | 8 | Day of week field |
| date_o | output | 8 | Date field |
| month_o | output | 8 | Month field, bit 7 is the century flag |
| year_o | output | 8 | Year field |
| sec_pulse | output | 1 | High in the cycle that precedes an advance |
| sqw_o | output | 1 | Square wave at one cycle per second |

## Verification
A write and a one-second advance can fall in the same cycle. To provoke this, the bench clears the divider with a seconds write, counts the divider to its last state, and presents a minutes write in exactly that cycle. It then expects `wr_ready` low for one cycle, the seconds stepped by the advance, and the written minutes value in place one edge later. A behavioural model that holds the time as integers predicts every output on every clock. That includes the stall and the way the divider's tick counting interleaves with a gated `tick_en` pattern.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int FIELD_COUNT = 7;
  localparam int RTC_ADDR_W  = 3;

  typedef enum logic [RTC_ADDR_W-1:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_WDAY  = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6,
    FLD_NONE  = 3'd7
  } rtc_field_e;

  // Bits a field keeps on a write; all others are forced to zero.
  function automatic logic [7:0] field_mask(input rtc_field_e f);
    case (f)
      FLD_SEC, FLD_MIN, FLD_HOUR: return 8'h7F;
      FLD_WDAY:                   return 8'h07;
      FLD_DATE:                   return 8'h3F;
      FLD_MONTH:                  return 8'h9F;
      FLD_YEAR:                   return 8'hFF;
      default:                    return 8'h00;
    endcase
  endfunction

  // Increment a two-digit packed BCD value (no range wrap).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Divisibility by four read straight from the two BCD digits.
  function automatic logic bcd_leap(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  // Last date of a BCD month.
  function automatic logic [7:0] month_last(input logic [4:0] mo, input logic leap);
    case (mo)
      5'h02:                      return leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_COUNT = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic hold,
  input  logic restart,
  output logic tick,
  output logic late_half
);
  localparam int CW = (DIV_COUNT > 2) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV_COUNT / 2);

  logic [CW-1:0] cnt;
  logic          step;

  assign step      = tick_en && !hold;
  assign tick      = step && (cnt == LAST);
  assign late_half = (cnt >= HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (step)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic [2:0] wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic       day_carry
);
  localparam int BASE60_N = 2;

  logic [7:0] b60_q   [BASE60_N];
  logic       stage_c [BASE60_N+1];

  assign stage_c[0] = adv;

  // Seconds and minutes are identical base-60 BCD stages.
  for (genvar i = 0; i < BASE60_N; i++) begin : g_b60
    logic [7:0] mask_i;
    assign mask_i       = field_mask(rtc_field_e'(i));
    assign stage_c[i+1] = stage_c[i] && (b60_q[i] == 8'h59);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          b60_q[i] <= 8'h00;
      else if (wr_en[i])   b60_q[i] <= wr_data & mask_i;
      else if (stage_c[i]) b60_q[i] <= (b60_q[i] == 8'h59) ? 8'h00 : bcd_inc(b60_q[i]);
    end
  end

  assign sec_q = b60_q[0];
  assign min_q = b60_q[1];

  logic [7:0] hour_nx;
  logic       hour_wrap;
  logic [7:0] hr_inc;
  logic       pm;
  logic [4:0] hr12;

  assign pm   = hour_q[5];
  assign hr12 = hour_q[4:0];

  always_comb begin
    hour_wrap = 1'b0;
    if (hour_q[6]) begin
      hr_inc = bcd_inc({3'b000, hr12});
      if (hr12 == 5'h12) begin
        hour_nx = {2'b01, pm, 5'h01};
      end else if (hr12 == 5'h11) begin
        hour_nx   = {2'b01, !pm, 5'h12};
        hour_wrap = pm;
      end else begin
        hour_nx = {2'b01, pm, hr_inc[4:0]};
      end
    end else begin
      hr_inc = bcd_inc(hour_q);
      if (hour_q[5:0] == 6'h23) begin
        hour_nx   = 8'h00;
        hour_wrap = 1'b1;
      end else begin
        hour_nx = hr_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hour_q <= 8'h00;
    else if (wr_en[2])           hour_q <= wr_data & field_mask(FLD_HOUR);
    else if (stage_c[BASE60_N])  hour_q <= hour_nx;
  end

  assign day_carry = stage_c[BASE60_N] && hour_wrap;
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic [3:0] wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] wday_q,
  output logic [7:0] date_q,
  output logic [7:0] month_q,
  output logic [7:0] year_q
);
  logic [7:0] last_day;
  logic       mo_carry;
  logic       yr_carry;
  logic       cent_flip;
  logic [7:0] mo_inc;

  assign last_day  = month_last(month_q[4:0], bcd_leap(year_q));
  assign mo_carry  = adv && (date_q == last_day);
  assign yr_carry  = mo_carry && (month_q[4:0] == 5'h12);
  assign cent_flip = yr_carry && (year_q == 8'h99);
  assign mo_inc    = bcd_inc({3'b000, month_q[4:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wday_q  <= 8'h01;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
    end else begin
      if (wr_en[0])  wday_q <= wr_data & field_mask(FLD_WDAY);
      else if (adv)  wday_q <= (wday_q == 8'h07) ? 8'h01 : wday_q + 8'h01;

      if (wr_en[1])  date_q <= wr_data & field_mask(FLD_DATE);
      else if (adv)  date_q <= mo_carry ? 8'h01 : bcd_inc(date_q);

      if (wr_en[2])      month_q <= wr_data & field_mask(FLD_MONTH);
      else if (mo_carry) month_q <= {month_q[7] ^ cent_flip, 2'b00,
                                     yr_carry ? 5'h01 : mo_inc[4:0]};

      if (wr_en[3])      year_q <= wr_data;
      else if (yr_carry) year_q <= cent_flip ? 8'h00 : bcd_inc(year_q);
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int DIV_COUNT = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       osc_disable,
  input  logic       sqw_en,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] seconds_o,
  output logic [7:0] minutes_o,
  output logic [7:0] hours_o,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       sec_pulse,
  output logic       sqw_o
);
  logic                   tick;
  logic                   late_half;
  logic                   wr_fire;
  logic [FIELD_COUNT-1:0] wr_sel;
  logic                   day_carry;

  assign wr_ready = !tick;
  assign wr_fire  = wr_valid && wr_ready;

  for (genvar f = 0; f < FIELD_COUNT; f++) begin : g_sel
    assign wr_sel[f] = wr_fire && (wr_addr == RTC_ADDR_W'(f));
  end

  rtc_prescaler #(.DIV_COUNT(DIV_COUNT)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .hold      (osc_disable),
    .restart   (wr_sel[FLD_SEC]),
    .tick      (tick),
    .late_half (late_half)
  );

  rtc_time_chain u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (tick),
    .wr_en     (wr_sel[2:0]),
    .wr_data   (wr_data),
    .sec_q     (seconds_o),
    .min_q     (minutes_o),
    .hour_q    (hours_o),
    .day_carry (day_carry)
  );

  rtc_date_chain u_date (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (day_carry),
    .wr_en   (wr_sel[6:3]),
    .wr_data (wr_data),
    .wday_q  (wday_o),
    .date_q  (date_o),
    .month_q (month_o),
    .year_q  (year_o)
  );

  assign sec_pulse = tick;
  assign sqw_o     = sqw_en && late_half;
endmodule

// File: rtl/rtc_calendar_checker.sv
module rtc_calendar_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_disable,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [2:0] wr_addr,
  input logic [7:0] seconds_o,
  input logic [7:0] minutes_o,
  input logic [7:0] hours_o,
  input logic [7:0] wday_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic       sec_pulse,
  input logic       sqw_o
);
  logic sec_wr;
  assign sec_wr = wr_valid && wr_ready && (wr_addr == 3'd0);

  AST_SEC_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_pulse && !sec_wr) |=> $stable(seconds_o)); // R2

  AST_CENTURY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sec_pulse) && $past(year_o) == 8'h99 && year_o == 8'h00)
      |-> (month_o[7] != $past(month_o[7]))); // R7

  AST_WDAY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wday_o != 8'h00); // R5

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (seconds_o[7] == 1'b0) && (minutes_o[7] == 1'b0) && (hours_o[7] == 1'b0) &&
    (date_o[7:6] == 2'b00) && (wday_o[7:3] == 5'b0) && (month_o[6:5] == 2'b00)); // R8

  AST_SQW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr |=> !sqw_o); // R9

  AST_FROZEN_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    osc_disable |-> !sec_pulse); // R11

  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> wr_ready); // R12
endmodule

bind rtc_calendar rtc_calendar_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .osc_disable (osc_disable),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_addr     (wr_addr),
  .seconds_o   (seconds_o),
  .minutes_o   (minutes_o),
  .hours_o     (hours_o),
  .wday_o      (wday_o),
  .date_o      (date_o),
  .month_o     (month_o),
  .year_o      (year_o),
  .sec_pulse   (sec_pulse),
  .sqw_o       (sqw_o)
);

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb;
  localparam int DIV = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       osc_disable = 1'b0;
  logic       sqw_en = 1'b0;
  logic       wr_valid = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready, sec_pulse, sqw_o;
  logic [7:0] seconds_o, minutes_o, hours_o, wday_o, date_o, month_o, year_o;

  always #2.5 clk = ~clk;

  rtc_calendar #(.DIV_COUNT(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .osc_disable(osc_disable),
    .sqw_en(sqw_en), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .seconds_o(seconds_o), .minutes_o(minutes_o),
    .hours_o(hours_o), .wday_o(wday_o), .date_o(date_o), .month_o(month_o),
    .year_o(year_o), .sec_pulse(sec_pulse), .sqw_o(sqw_o)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Behavioural reference: plain integers, hour kept as 0..23 plus a format flag.
  int m_sec, m_min, m_hr, m_wday, m_date, m_mon, m_year, m_cnt;
  bit m_cent, m_mode12;

  function automatic int from_bcd(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_in(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_hours();
    int h12;
    if (!m_mode12) return to_bcd(m_hr);
    h12 = (m_hr % 12 == 0) ? 12 : m_hr % 12;
    return 8'h40 | ((m_hr >= 12) ? 8'h20 : 8'h00) | to_bcd(h12);
  endfunction

  function automatic bit exp_tick();
    return tick_en && !osc_disable && (m_cnt == DIV - 1);
  endfunction

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_hr = 0; m_wday = 1; m_date = 1; m_mon = 1; m_year = 0;
    m_cent = 0; m_mode12 = 0; m_cnt = 0;
  endtask

  task automatic model_second();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_wday = (m_wday == 7) ? 1 : m_wday + 1;
    m_date++;
    if (m_date <= days_in(m_mon, m_year)) return;
    m_date = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1; m_year++;
    if (m_year <= 99) return;
    m_year = 0; m_cent = !m_cent;
  endtask

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    case (a)
      3'd0: m_sec = from_bcd({1'b0, d[6:0]});
      3'd1: m_min = from_bcd({1'b0, d[6:0]});
      3'd2: begin
        m_mode12 = d[6];
        if (d[6]) m_hr = (from_bcd({3'b0, d[4:0]}) % 12) + (d[5] ? 12 : 0);
        else      m_hr = from_bcd({2'b0, d[5:0]});
      end
      3'd3: m_wday = int'(d[2:0]);
      3'd4: m_date = from_bcd({2'b0, d[5:0]});
      3'd5: begin m_mon = from_bcd({3'b0, d[4:0]}); m_cent = d[7]; end
      3'd6: m_year = from_bcd(d);
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    bit t, fire;
    cycles++;
    if (!rst_n) model_reset();
    else begin
      t    = exp_tick();
      fire = wr_valid && !t;
      if (t) model_second();
      if (fire) model_write(wr_addr, wr_data);
      if (fire && wr_addr == 3'd0) m_cnt = 0;
      else if (tick_en && !osc_disable) m_cnt = t ? 0 : m_cnt + 1;
    end
  end

  task automatic chk(input string tag, input string name, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, name, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "seconds", seconds_o, to_bcd(m_sec));
      chk("R2", "minutes", minutes_o, to_bcd(m_min));
      chk("R3 R4", "hours", hours_o, exp_hours());
      chk("R5", "wday", wday_o, 8'(m_wday));
      chk("R6", "date", date_o, to_bcd(m_date));
      chk("R7", "month", month_o, {m_cent, 7'b0} | to_bcd(m_mon));
      chk("R7", "year", year_o, to_bcd(m_year));
      chk("R2", "sec_pulse", {7'b0, sec_pulse}, {7'b0, exp_tick()});
      chk("R12", "wr_ready", {7'b0, wr_ready}, {7'b0, !exp_tick()});
      chk("R10", "sqw", {7'b0, sqw_o}, {7'b0, sqw_en && (m_cnt >= DIV / 2)});
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bit acc;
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    do begin
      @(negedge clk); acc = wr_ready;
      @(posedge clk); #1;
    end while (!acc);
    wr_valid = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                         input logic [7:0] wd, input logic [7:0] hr, input logic [7:0] mi,
                         input logic [7:0] se);
    wr(3'd0, 8'h00);
    wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, wd); wr(3'd2, hr); wr(3'd1, mi);
    wr(3'd0, se);
  endtask

  logic [7:0] keep_a, keep_b, keep_c;

  initial begin
    step(3);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "rst seconds", seconds_o, 8'h00);
    chk("R1", "rst hours", hours_o, 8'h00);
    chk("R1", "rst wday", wday_o, 8'h01);
    chk("R1", "rst date", date_o, 8'h01);
    chk("R1", "rst month", month_o, 8'h01);
    chk("R1", "rst year", year_o, 8'h00);

    // R3 R5 R6: midnight in a common-year February
    set_all(8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
    step(2 * DIV + 3);
    chk("R3", "midnight hours", hours_o, 8'h00);
    chk("R5", "wday wrap", wday_o, 8'h01);
    chk("R6", "feb28 common", date_o, 8'h01);
    chk("R6", "into march", month_o, 8'h03);

    // R6 leap February
    set_all(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    step(DIV + 3);
    chk("R6", "leap feb29", date_o, 8'h29);
    wr(3'd0, 8'h00); wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    step(DIV + 3);
    chk("R6", "leap end", date_o, 8'h01);
    chk("R6", "leap month", month_o, 8'h03);

    // R7 year and century
    set_all(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    step(DIV + 3);
    chk("R7", "year wrap", year_o, 8'h00);
    chk("R7", "century set", month_o, 8'h81);
    set_all(8'h99, 8'h92, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    step(DIV + 3);
    chk("R7", "century clear", month_o, 8'h01);

    // R4 12-hour crossings
    set_all(8'h24, 8'h04, 8'h30, 8'h02, 8'h71, 8'h59, 8'h59);
    step(DIV + 3);
    chk("R4", "11PM to 12AM", hours_o, 8'h52);
    chk("R4", "date at PM-AM", date_o, 8'h01);
    chk("R6", "april 30", month_o, 8'h05);
    wr(3'd0, 8'h00); wr(3'd2, 8'h52); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    step(DIV + 3);
    chk("R4", "12AM to 1AM", hours_o, 8'h41);
    wr(3'd0, 8'h00); wr(3'd2, 8'h51); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    step(DIV + 3);
    chk("R4", "11AM to 12PM", hours_o, 8'h72);
    chk("R4", "no date at noon", date_o, 8'h01);

    // R8 masking and ignored address
    wr(3'd0, 8'hC5);
    wr(3'd3, 8'hFB);
    wr(3'd2, 8'hA3);
    keep_a = minutes_o; keep_b = date_o; keep_c = year_o;
    wr(3'd7, 8'hFF);
    chk("R8", "sec masked", seconds_o, 8'h45);
    chk("R8", "wday masked", wday_o, 8'h03);
    chk("R8", "hour masked", hours_o, 8'h23);
    chk("R8", "addr7 minutes", minutes_o, keep_a);
    chk("R8", "addr7 date", date_o, keep_b);
    chk("R8", "addr7 year", year_o, keep_c);

    // R9 R10 divider restart and square wave
    sqw_en = 1'b1;
    step(7);
    wr(3'd0, 8'h10);
    chk("R9", "sqw after write", {7'b0, sqw_o}, 8'h00);
    step(DIV / 2 - 1);
    chk("R9", "sqw before half", {7'b0, sqw_o}, 8'h00);
    step(1);
    chk("R10", "sqw at half", {7'b0, sqw_o}, 8'h01);
    sqw_en = 1'b0; #1;
    chk("R10", "sqw gated", {7'b0, sqw_o}, 8'h00);

    // R11 freeze, writes still land
    osc_disable = 1'b1;
    keep_a = seconds_o;
    step(4 * DIV);
    chk("R11", "frozen seconds", seconds_o, keep_a);
    wr(3'd1, 8'h12);
    chk("R11", "write while frozen", minutes_o, 8'h12);
    osc_disable = 1'b0;

    // R12 write presented in the advance cycle
    wr(3'd0, 8'h10);
    step(DIV - 1);
    wr_valid = 1'b1; wr_addr = 3'd1; wr_data = 8'h33;
    @(negedge clk);
    chk("R12", "stall ready", {7'b0, wr_ready}, 8'h00);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R12", "ready again", {7'b0, wr_ready}, 8'h01);
    @(posedge clk); #1;
    wr_valid = 1'b0;
    chk("R12", "seconds advanced", seconds_o, 8'h11);
    chk("R12", "minutes written", minutes_o, 8'h33);

    // R2 gated fast enable: half the cycles count
    wr(3'd0, 8'h00);
    for (int i = 0; i < 2 * DIV; i++) begin
      tick_en = (i % 2 == 1);
      step(1);
    end
    tick_en = 1'b1;
    chk("R2", "gated count", seconds_o, 8'h01);
    step(3 * DIV);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule